// File: doc/BRIEF.md
# Synthesizer Configuration Loader

This block holds the three configuration words of a frequency synthesizer: a 9-bit loop divisor, a 2-bit output divider select and a 3-bit test select. The words can be written over two paths that share one set of holding registers.

The parallel path copies the divisor and divider-select pins when its strobe goes from low to high. The serial path first collects a 14-bit frame in a shift register that advances on every rising edge of a serial clock. It then commits the whole frame when a serial load strobe goes from high to low.

The strobes, serial clock and serial data come from outside the system clock domain. Each passes through a two-stage synchronizer, and every load acts on the edge detected after synchronization. The parallel path takes precedence. The test select is held at zero for as long as the parallel strobe is low.

Top module: `synth_cfg_loader`

## Requirements
- R1: While and after reset, before any load, loopDiv is all ones (511), outSel is 2'b11 and testSel is 3'b000.
- R2: Each rising edge of serClk shifts serData into a 14-bit frame, and only the last 14 bits shifted count. The frame order is testSel (3 bits), then outSel (2 bits), then loopDiv (9 bits), each field most significant bit first. The first bit sent ends up as testSel[2] and the last as loopDiv[0].
- R3: A high-to-low transition of serLoad while parStrobe is high copies the frame into testSel, outSel and loopDiv. The new values appear on the third rising clock edge after the input transition.
- R4: A high-to-low transition of serLoad while parStrobe is low changes no output.
- R5: A low-to-high transition of parStrobe while serLoad is low copies mPins into loopDiv and nPins into outSel, and testSel stays 000. The outputs still hold their old values after two rising clock edges and show the new ones after the third.
- R6: A low-to-high transition of parStrobe while serLoad is high changes no output.
- R7: Once parStrobe has been low for three clock edges, testSel reads 000 and loopDiv and outSel are unchanged. The test select can never be written from the pins.
- R8: When a serLoad fall and a parStrobe rise are detected in the same cycle, the parallel values win and testSel is 000.
- R9: Shifting serial bits, and changing mPins or nPins without a parStrobe rise, leave all outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial shift clock, asynchronous |
| serData | input | 1 | Serial frame data, sampled on serClk rise |
| serLoad | input | 1 | Serial commit strobe, acts on falling edge |
| parStrobe | input | 1 | Parallel commit strobe, acts on rising edge; low clears test select |
| mPins | input | 9 | Parallel loop divisor value |
| nPins | input | 2 | Parallel output divider select value |
| loopDiv | output | 9 | Held loop divisor |
| outSel | output | 2 | Held output divider select |
| testSel | output | 3 | Held test select |

## Verification
Every input passes through two synchronizer stages before its edge is detected, and the holding register updates one edge after that. A load therefore shows at the outputs on the third rising clock edge after the strobe pin changes. Serial bits enter the shift register on the same three-edge schedule. The bench changes inputs on falling clock edges and, for parallel loads, samples just after the second and just after the third rising edge to pin down that latency exactly. In all other cases it holds each strobe and each serial clock level for at least three cycles, so every result has settled before it is sampled.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  // Control-to-datapath strobes, one cycle wide each
  typedef struct packed {
    logic shiftEn;     // synchronized serial clock rose
    logic shiftBit;    // synchronized serial data
    logic serCapture;  // serial load fell while parallel strobe high
    logic parCapture;  // parallel strobe rose while serial load low
    logic testClear;   // parallel strobe currently low
  } cfgStrb_t;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] pipe [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) pipe[s] <= '0;
          else       pipe[s] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) pipe[s] <= '0;
          else       pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/cfg_loader_ctrl.sv
module cfg_loader_ctrl
  import cfg_loader_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     serClk,
  input  logic     serData,
  input  logic     serLoad,
  input  logic     parStrobe,
  output cfgStrb_t strb
);

  localparam int IN_W = 4;

  logic [IN_W-1:0] rawIn;
  logic [IN_W-1:0] syncIn;
  logic clkSync, dataSync, loadSync, parSync;
  logic clkPrev, loadPrev, parPrev;

  assign rawIn = {parStrobe, serLoad, serData, serClk};

  cfg_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (rawIn),
    .dout (syncIn)
  );

  assign {parSync, loadSync, dataSync, clkSync} = syncIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev  <= 1'b0;
      loadPrev <= 1'b0;
      parPrev  <= 1'b0;
    end else begin
      clkPrev  <= clkSync;
      loadPrev <= loadSync;
      parPrev  <= parSync;
    end
  end

  always_comb begin
    strb.shiftEn    = clkSync & ~clkPrev;
    strb.shiftBit   = dataSync;
    strb.serCapture = loadPrev & ~loadSync & parSync;
    strb.parCapture = parSync & ~parPrev & ~loadSync;
    strb.testClear  = ~parSync;
  end

endmodule

// File: rtl/cfg_loader_dp.sv
module cfg_loader_dp
  import cfg_loader_pkg::*;
#(
  parameter int LOOP_W = 9,
  parameter int SEL_W  = 2,
  parameter int TEST_W = 3
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  cfgStrb_t                         strb,
  input  logic [LOOP_W-1:0]                mPins,
  input  logic [SEL_W-1:0]                 nPins,
  output logic [LOOP_W-1:0]                loopDiv,
  output logic [SEL_W-1:0]                 outSel,
  output logic [TEST_W-1:0]                testSel,
  output logic [LOOP_W+SEL_W+TEST_W-1:0]   frameWord
);

  localparam int FRAME_W = LOOP_W + SEL_W + TEST_W;
  localparam int SEL_LSB = LOOP_W;
  localparam int TST_LSB = LOOP_W + SEL_W;

  logic [FRAME_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             shiftReg <= '0;
    else if (strb.shiftEn) shiftReg <= {shiftReg[FRAME_W-2:0], strb.shiftBit};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loopDiv <= '1;
      outSel  <= '1;
      testSel <= '0;
    end else if (strb.parCapture) begin
      loopDiv <= mPins;
      outSel  <= nPins;
      testSel <= '0;
    end else if (strb.serCapture) begin
      loopDiv <= shiftReg[SEL_LSB-1:0];
      outSel  <= shiftReg[TST_LSB-1:SEL_LSB];
      testSel <= shiftReg[FRAME_W-1:TST_LSB];
    end else if (strb.testClear) begin
      testSel <= '0;
    end
  end

  assign frameWord = shiftReg;

endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int LOOP_W      = 9,
  parameter int SEL_W       = 2,
  parameter int TEST_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              serData,
  input  logic              serLoad,
  input  logic              parStrobe,
  input  logic [LOOP_W-1:0] mPins,
  input  logic [SEL_W-1:0]  nPins,
  output logic [LOOP_W-1:0] loopDiv,
  output logic [SEL_W-1:0]  outSel,
  output logic [TEST_W-1:0] testSel
);

  localparam int FRAME_W = LOOP_W + SEL_W + TEST_W;

  cfgStrb_t           strb;
  logic [FRAME_W-1:0] frameWord;

  cfg_loader_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .serClk    (serClk),
    .serData   (serData),
    .serLoad   (serLoad),
    .parStrobe (parStrobe),
    .strb      (strb)
  );

  cfg_loader_dp #(.LOOP_W(LOOP_W), .SEL_W(SEL_W), .TEST_W(TEST_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .mPins     (mPins),
    .nPins     (nPins),
    .loopDiv   (loopDiv),
    .outSel    (outSel),
    .testSel   (testSel),
    .frameWord (frameWord)
  );

endmodule

// File: rtl/synth_cfg_loader_chk.sv
module synth_cfg_loader_chk
  import cfg_loader_pkg::*;
#(
  parameter int LOOP_W = 9,
  parameter int SEL_W  = 2,
  parameter int TEST_W = 3
) (
  input logic                           clk,
  input logic                           rstN,
  input cfgStrb_t                       strb,
  input logic [LOOP_W+SEL_W+TEST_W-1:0] frameWord,
  input logic [LOOP_W-1:0]              mPins,
  input logic [SEL_W-1:0]               nPins,
  input logic [LOOP_W-1:0]              loopDiv,
  input logic [SEL_W-1:0]               outSel,
  input logic [TEST_W-1:0]              testSel
);

  localparam int FRAME_W = LOOP_W + SEL_W + TEST_W;

  // R2
  shift_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftEn |=> (frameWord[0] == $past(strb.shiftBit)) &&
                     (frameWord[FRAME_W-1:1] == $past(frameWord[FRAME_W-2:0])));

  // R3
  ser_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.serCapture && !strb.parCapture) |=>
      ({testSel, outSel, loopDiv} == $past(frameWord)));

  // R5
  par_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.parCapture |=> (loopDiv == $past(mPins)) && (outSel == $past(nPins)) &&
                        (testSel == '0));

  // R7
  test_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.testClear |=> (testSel == '0));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.parCapture || strb.serCapture || strb.testClear) |=>
      $stable({loopDiv, outSel, testSel}));

endmodule

bind synth_cfg_loader synth_cfg_loader_chk #(
  .LOOP_W(LOOP_W), .SEL_W(SEL_W), .TEST_W(TEST_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .strb      (strb),
  .frameWord (frameWord),
  .mPins     (mPins),
  .nPins     (nPins),
  .loopDiv   (loopDiv),
  .outSel    (outSel),
  .testSel   (testSel)
);

// File: tb/synth_cfg_loader_bench.sv
module synth_cfg_loader_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LW = 9;
  localparam int SW = 2;
  localparam int TW = 3;
  localparam int FW = LW + SW + TW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          serClk = 1'b0;
  logic          serData = 1'b0;
  logic          serLoad = 1'b0;
  logic          parStrobe = 1'b0;
  logic [LW-1:0] mPins = '1;
  logic [SW-1:0] nPins = '1;
  logic [LW-1:0] loopDiv;
  logic [SW-1:0] outSel;
  logic [TW-1:0] testSel;

  int vectors = 0;
  int misses = 0;
  bit finished = 1'b0;

  logic [LW-1:0] expM = '1;
  logic [SW-1:0] expN = '1;
  logic [TW-1:0] expT = '0;
  logic [FW-1:0] srModel = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  synth_cfg_loader u_synth_cfg_loader (
    .clk       (clk),
    .rstN      (rstN),
    .serClk    (serClk),
    .serData   (serData),
    .serLoad   (serLoad),
    .parStrobe (parStrobe),
    .mPins     (mPins),
    .nPins     (nPins),
    .loopDiv   (loopDiv),
    .outSel    (outSel),
    .testSel   (testSel)
  );

  function automatic logic [FW-1:0] packFrame(logic [TW-1:0] t, logic [SW-1:0] n,
                                               logic [LW-1:0] m);
    return {t, n, m};
  endfunction

  task automatic idle(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      misses++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic checkAll(string req);
    check({req, " loopDiv"}, 32'(loopDiv), 32'(expM));
    check({req, " outSel"},  32'(outSel),  32'(expN));
    check({req, " testSel"}, 32'(testSel), 32'(expT));
  endtask

  task automatic shiftBits(logic [FW-1:0] bits, int count);
    for (int i = count - 1; i >= 0; i--) begin
      serData = bits[i];
      idle(3);
      serClk = 1'b1;
      srModel = {srModel[FW-2:0], bits[i]};
      idle(3);
      serClk = 1'b0;
    end
    idle(1);
  endtask

  task automatic serialLoad();
    serLoad = 1'b1;
    idle(4);
    serLoad = 1'b0;
    if (parStrobe) {expT, expN, expM} = srModel;
    idle(4);
  endtask

  task automatic parDrop();
    parStrobe = 1'b0;
    idle(4);
    expT = '0;
  endtask

  task automatic parRise(logic [LW-1:0] m, logic [SW-1:0] n);
    mPins = m;
    nPins = n;
    idle(1);
    parStrobe = 1'b1;
    if (!serLoad) begin
      idle(2);
      checkAll("R5 latency, old value after two edges");
      idle(1);
      expM = m;
      expN = n;
      expT = '0;
      checkAll("R5 new value on third edge");
    end else begin
      idle(4);
      checkAll("R6 parallel rise ignored while serial load high");
    end
    idle(1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_C0DE));
    idle(3);
    checkAll("R1 during reset");
    rstN = 1'b1;
    idle(4);
    checkAll("R1 after reset");

    // Parallel load from the power-on low strobe
    parRise(9'd200, 2'b01);

    // Serial frame: shifting alone holds outputs, load commits it
    shiftBits(packFrame(3'b101, 2'b10, 9'd400), FW);
    checkAll("R9 shifting holds outputs");
    serialLoad();
    checkAll("R3 serial frame committed");
    check("R2 first bit lands in testSel[2]", 32'(testSel[2]), 32'd1);
    check("R2 last bit lands in loopDiv[0]", 32'(loopDiv[0]), 32'd0);

    // Pins moving without a strobe rise
    mPins = 9'h0A5;
    nPins = 2'b00;
    idle(6);
    checkAll("R9 pin changes held off");

    // Parallel strobe low clears the test field only
    parDrop();
    checkAll("R7 test select cleared, divisors kept");

    // Serial commit while parallel strobe low is ignored
    shiftBits(packFrame(3'b011, 2'b01, 9'd311), FW);
    serialLoad();
    checkAll("R4 serial load ignored while parallel low");

    // Parallel rise blocked by serial load high, then serial commits
    serLoad = 1'b1;
    idle(4);
    parRise(9'd17, 2'b10);
    serLoad = 1'b0;
    {expT, expN, expM} = srModel;
    idle(4);
    checkAll("R3 serial commit after blocked parallel rise");

    // Same-cycle serial fall and parallel rise
    parDrop();
    shiftBits(packFrame(3'b111, 2'b00, 9'd99), FW);
    serLoad = 1'b1;
    mPins = 9'd333;
    nPins = 2'b11;
    idle(4);
    serLoad = 1'b0;
    parStrobe = 1'b1;
    expM = 9'd333;
    expN = 2'b11;
    expT = '0;
    idle(4);
    checkAll("R8 parallel wins over simultaneous serial");

    // Over-long stream: only the final 14 bits count
    shiftBits(14'h3FFF, 6);
    shiftBits(packFrame(3'b110, 2'b01, 9'h12C), FW);
    serialLoad();
    checkAll("R2 last fourteen bits only");

    // Constrained random mix
    for (int it = 0; it < 30; it++) begin
      case ($urandom_range(0, 3))
        0: begin
          shiftBits(FW'($urandom), FW);
          serialLoad();
          if (parStrobe) checkAll("R3 random serial commit");
          else           checkAll("R4 random serial ignored");
        end
        1: begin
          if (parStrobe) parDrop();
          parRise(LW'($urandom), SW'($urandom));
        end
        2: begin
          parDrop();
          checkAll("R7 random strobe low");
        end
        default: begin
          shiftBits(FW'($urandom), $urandom_range(1, 5));
          mPins = LW'($urandom);
          nPins = SW'($urandom);
          idle(4);
          checkAll("R9 random hold");
        end
      endcase
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule